// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This block sits next to a memory and carries out one atomic operation per request. A request names an operation through a 5-bit function code and an element size through a 2-bit width code. A flag marks the request as load-type, which returns a value to a register, or store-type, which only updates memory. The request also carries a byte address and two register operands. The engine reads the target element and, for the bounded-counter and twin operations, reads a neighbouring element as well. It then computes the new value, writes it back when the operation calls for a write, and reports the old value together with a write-back strobe.

The memory side is a single synchronous port with a one-cycle read latency. The engine holds a lock signal high for the whole read-compute-write sequence, so no other agent can slip an access in between. The caller sees `busy` from the cycle after acceptance until the result is ready, followed by a one-cycle `done`. The result, the write-back strobe and the error flag are valid in that `done` cycle.

Top module: `amo_unit`

## Requirements
- R1: The width code selects the element size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. Memory is little-endian, and only the bytes of the addressed element (and of the neighbour, where one is used) change. The returned value is zero-extended to 64 bits.
- R2: The arithmetic and logic codes are 00000 (add), 00001 (XOR), 00010 (OR) and 00011 (AND). Each stores the old element combined with operand A, wrapped to the element width.
- R3: The min/max codes are 00100 (max unsigned), 00101 (max signed), 00110 (min unsigned) and 00111 (min signed). They compare only the low element-width bits of the memory value and of operand A, and the signed forms sign-extend from the element width first. They store the winner.
- R4: Load code 01000 (swap) stores operand A.
- R5: Load code 10000 stores operand B only when the old element differs from operand A. Otherwise memory is left unchanged.
- R6: Load code 11000 (increment bounded) reads the element at the address and the bound element one size above it. When the two differ it stores the old value plus one; when they are equal it writes nothing. Load code 11001 (increment equal) makes the same update only when the two elements are equal.
- R7: Load code 11100 (decrement bounded) reads the bound element one size below the address. When it differs from the element at the address, it stores the old value minus one; otherwise it writes nothing.
- R8: A load-type request returns the old element with the write-back strobe high. The exceptions are the three counter codes (11000, 11001, 11100) when no update was made: they return the width's most-negative value (only the top bit of the element set) instead. A store-type request never raises the write-back strobe.
- R9: Store-type requests accept codes 00000 to 00111 with the same updates as the load forms. Store code 11000 (twin) writes operand A to both the element and its upper neighbour, only when those two elements are equal.
- R10: Any other code completes with the error flag high during `done`, performs no memory write, and leaves the write-back strobe low. `done` follows acceptance by one cycle in this case.
- R11: A request is accepted only while both `busy` and `done` are low. `busy` is high from the cycle after acceptance until `done`, and `done` lasts exactly one cycle. `done` comes 4 cycles after acceptance, or 5 for a twin store that writes. Requests presented while busy are ignored.
- R12: `mem_lock` is high for the whole sequence, and every memory read or write happens while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_store | input | 1 | 1 = store-type request, 0 = load-type |
| req_fc | input | 5 | Function code |
| req_ew | input | 2 | Element width code |
| req_addr | input | ADDR_W | Byte address of the element |
| req_opa | input | 64 | Operand A (source or compare value) |
| req_opb | input | 64 | Operand B (replacement value for code 10000) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_wb | output | 1 | Result is to be written to a register |
| rsp_data | output | 64 | Old element, zero-extended, or most-negative marker |
| rsp_err | output | 1 | Unsupported code, valid with done |
| mem_lock | output | 1 | Memory port held for this sequence |
| mem_rd | output | 1 | Read strobe, data returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Byte address for the access |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 64 | Write data, low bytes used |
| mem_rdata | input | 64 | Read data, zero-extended |

## Verification
For the counter and twin operations, two things land in the same cycle: the neighbour element returns from memory, and the decision whether to write is made. The freshly returned bound is compared against the held value, and the write strobe follows in that cycle. The sweep provokes both outcomes by placing a neighbour equal to the element in one pattern and unequal in the others, at every width and on both sides of the address. The sweep then judges the returned value, the whole memory image and the completion latency against a reference computed in the bench.

// File: rtl/amo_pkg.sv
// Shared constants, types and width helpers for the atomic engine.
// Assumes a 64-bit data path; element widths are 8, 16, 32 or 64 bits.
package amo_pkg;
    localparam int WORD_W = 64;
    typedef logic [WORD_W-1:0] word_t;

    localparam logic [4:0] FC_ADD  = 5'b00000;
    localparam logic [4:0] FC_XOR  = 5'b00001;
    localparam logic [4:0] FC_OR   = 5'b00010;
    localparam logic [4:0] FC_AND  = 5'b00011;
    localparam logic [4:0] FC_MAXU = 5'b00100;
    localparam logic [4:0] FC_MAXS = 5'b00101;
    localparam logic [4:0] FC_MINU = 5'b00110;
    localparam logic [4:0] FC_MINS = 5'b00111;
    localparam logic [4:0] FC_SWAP = 5'b01000;
    localparam logic [4:0] FC_CSNE = 5'b10000;
    localparam logic [4:0] FC_INCB = 5'b11000;
    localparam logic [4:0] FC_INCE = 5'b11001;
    localparam logic [4:0] FC_DECB = 5'b11100;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_A, S_RD_B, S_CALC, S_WR2, S_FIN
    } amo_state_t;

    // Mask of the bits that belong to an element of the given width.
    function automatic word_t ew_mask(input logic [1:0] ew);
        case (ew)
            2'd0:    return word_t'(64'hFF);
            2'd1:    return word_t'(64'hFFFF);
            2'd2:    return word_t'(64'hFFFF_FFFF);
            default: return '1;
        endcase
    endfunction

    // Sign-extend an element from its width to the full word.
    function automatic word_t ew_sext(input word_t v, input logic [1:0] ew);
        case (ew)
            2'd0:    return {{56{v[7]}}, v[7:0]};
            2'd1:    return {{48{v[15]}}, v[15:0]};
            2'd2:    return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    // Most-negative value of the width, zero-extended to the word.
    function automatic word_t ew_minneg(input logic [1:0] ew);
        case (ew)
            2'd0:    return word_t'(64'h80);
            2'd1:    return word_t'(64'h8000);
            2'd2:    return word_t'(64'h8000_0000);
            default: return word_t'(64'h8000_0000_0000_0000);
        endcase
    endfunction
endpackage

// File: rtl/amo_decode.sv
// Classifies a function code for a load- or store-type request.
// Assumes codes outside the supported sets are reported as not legal.
module amo_decode
    import amo_pkg::*;
(
    input  logic       store_i,
    input  logic [4:0] fc_i,
    output logic       legal_o,
    output logic       pair_o,
    output logic       below_o
);
    logic basic_op;

    // Decide legality and which neighbour element an operation needs.
    always_comb begin
        basic_op = (fc_i[4:3] == 2'b00);
        if (store_i)
            legal_o = basic_op || (fc_i == FC_INCB);
        else
            legal_o = basic_op || (fc_i == FC_SWAP) || (fc_i == FC_CSNE) ||
                      (fc_i == FC_INCB) || (fc_i == FC_INCE) || (fc_i == FC_DECB);
        pair_o  = legal_o && (fc_i[4:3] == 2'b11);
        below_o = legal_o && !store_i && (fc_i == FC_DECB);
    end
endmodule

// File: rtl/amo_alu.sv
// Computes the new element, the write decision and the returned value.
// Assumes cur_i holds the element and nbr_i the neighbour (pair codes only).
module amo_alu
    import amo_pkg::*;
(
    input  logic       store_i,
    input  logic [4:0] fc_i,
    input  logic [1:0] ew_i,
    input  word_t      cur_i,
    input  word_t      nbr_i,
    input  word_t      opa_i,
    input  word_t      opb_i,
    output logic       wr_o,
    output logic       twin_o,
    output word_t      new_o,
    output word_t      res_o
);
    word_t mask, c_m, n_m, a_m, b_m;
    logic  gt_u, gt_s;

    // Bring every operand down to the element width.
    always_comb begin
        mask = ew_mask(ew_i);
        c_m  = cur_i & mask;
        n_m  = nbr_i & mask;
        a_m  = opa_i & mask;
        b_m  = opb_i & mask;
        gt_u = a_m > c_m;
        gt_s = $signed(ew_sext(a_m, ew_i)) > $signed(ew_sext(c_m, ew_i));
    end

    // Select the update for the function code.
    always_comb begin
        wr_o   = 1'b1;
        twin_o = 1'b0;
        new_o  = c_m;
        res_o  = c_m;
        case (fc_i)
            FC_ADD:  new_o = (c_m + a_m) & mask;
            FC_XOR:  new_o = c_m ^ a_m;
            FC_OR:   new_o = c_m | a_m;
            FC_AND:  new_o = c_m & a_m;
            FC_MAXU: new_o = gt_u ? a_m : c_m;
            FC_MAXS: new_o = gt_s ? a_m : c_m;
            FC_MINU: new_o = (!gt_u && a_m != c_m) ? a_m : c_m;
            FC_MINS: new_o = (!gt_s && a_m != c_m) ? a_m : c_m;
            FC_SWAP: new_o = a_m;
            FC_CSNE: begin
                wr_o  = (c_m != a_m);
                new_o = b_m;
            end
            FC_INCB: begin
                if (store_i) begin
                    twin_o = 1'b1;
                    wr_o   = (c_m == n_m);
                    new_o  = a_m;
                end else begin
                    wr_o  = (c_m != n_m);
                    new_o = (c_m + 1'b1) & mask;
                    res_o = wr_o ? c_m : ew_minneg(ew_i);
                end
            end
            FC_INCE: begin
                wr_o  = (c_m == n_m);
                new_o = (c_m + 1'b1) & mask;
                res_o = wr_o ? c_m : ew_minneg(ew_i);
            end
            FC_DECB: begin
                wr_o  = (c_m != n_m);
                new_o = (c_m - 1'b1) & mask;
                res_o = wr_o ? c_m : ew_minneg(ew_i);
            end
            default: wr_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/amo_unit.sv
// Atomic read-modify-write engine: accepts one request when idle, reads the
// element (and a neighbour), writes the update and reports the old value.
// Assumes a memory port with one-cycle read latency and aligned addresses.
module amo_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [4:0]        req_fc,
    input  logic [1:0]        req_ew,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_opa,
    input  logic [63:0]       req_opb,
    output logic              busy,
    output logic              done,
    output logic              rsp_wb,
    output logic [63:0]       rsp_data,
    output logic              rsp_err,
    output logic              mem_lock,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata
);
    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

    amo_state_t        st_q;
    logic              store_q, pair_q, below_q, err_q, wb_q;
    logic [4:0]        fc_q;
    logic [1:0]        ew_q;
    logic [ADDR_W-1:0] addr_q, step, nb_addr;
    word_t             opa_q, opb_q, cur_q, res_q, nval_q;
    logic              dec_legal, dec_pair, dec_below;
    logic              alu_wr, alu_twin;
    word_t             alu_new, alu_res;

    amo_decode u_dec (
        .store_i (req_store),
        .fc_i    (req_fc),
        .legal_o (dec_legal),
        .pair_o  (dec_pair),
        .below_o (dec_below)
    );

    amo_alu u_alu (
        .store_i (store_q),
        .fc_i    (fc_q),
        .ew_i    (ew_q),
        .cur_i   (cur_q),
        .nbr_i   (mem_rdata),
        .opa_i   (opa_q),
        .opb_i   (opb_q),
        .wr_o    (alu_wr),
        .twin_o  (alu_twin),
        .new_o   (alu_new),
        .res_o   (alu_res)
    );

    // Neighbour address: one element above, or below for the decrement form.
    always_comb begin
        step    = ONE_A << ew_q;
        nb_addr = below_q ? (addr_q - step) : (addr_q + step);
    end

    // Sequencer: accept, read element, read neighbour, update, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            store_q <= 1'b0;
            pair_q  <= 1'b0;
            below_q <= 1'b0;
            err_q   <= 1'b0;
            wb_q    <= 1'b0;
            fc_q    <= '0;
            ew_q    <= '0;
            addr_q  <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            cur_q   <= '0;
            res_q   <= '0;
            nval_q  <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (req_valid) begin
                    store_q <= req_store;
                    fc_q    <= req_fc;
                    ew_q    <= req_ew;
                    addr_q  <= req_addr;
                    opa_q   <= req_opa;
                    opb_q   <= req_opb;
                    pair_q  <= dec_pair;
                    below_q <= dec_below;
                    err_q   <= !dec_legal;
                    wb_q    <= 1'b0;
                    res_q   <= '0;
                    st_q    <= dec_legal ? S_RD_A : S_FIN;
                end
                S_RD_A: st_q <= S_RD_B;
                S_RD_B: begin
                    cur_q <= mem_rdata;
                    st_q  <= S_CALC;
                end
                S_CALC: begin
                    res_q  <= alu_res;
                    wb_q   <= !store_q;
                    nval_q <= alu_new;
                    st_q   <= (alu_twin && alu_wr) ? S_WR2 : S_FIN;
                end
                S_WR2:   st_q <= S_FIN;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Drive the memory port and the response from the current state.
    always_comb begin
        busy      = (st_q != S_IDLE) && (st_q != S_FIN);
        done      = (st_q == S_FIN);
        mem_lock  = busy;
        mem_rd    = (st_q == S_RD_A) || ((st_q == S_RD_B) && pair_q);
        mem_wr    = ((st_q == S_CALC) && alu_wr) || (st_q == S_WR2);
        mem_addr  = ((st_q == S_RD_B) || (st_q == S_WR2)) ? nb_addr : addr_q;
        mem_size  = ew_q;
        mem_wdata = (st_q == S_WR2) ? nval_q : alu_new;
        rsp_data  = res_q;
        rsp_wb    = done && wb_q;
        rsp_err   = done && err_q;
    end
endmodule

// File: rtl/amo_unit_chk.sv
// Protocol checker for the atomic engine, attached by bind.
// Assumes it sees the top-level ports only.
module amo_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic rsp_wb,
    input logic rsp_err,
    input logic mem_lock,
    input logic mem_rd,
    input logic mem_wr
);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !done) |=> (busy || done));
    a_r12_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> mem_lock);
    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r10_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!mem_wr && $past(!mem_wr)));
    a_r8_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb |-> (done && !rsp_err));
endmodule

bind amo_unit amo_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rsp_wb    (rsp_wb),
    .rsp_err   (rsp_err),
    .mem_lock  (mem_lock),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_store = 1'b0;
    logic [4:0]    req_fc = '0;
    logic [1:0]    req_ew = '0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_opa = '0, req_opb = '0;
    logic          busy, done, rsp_wb, rsp_err, mem_lock, mem_rd, mem_wr;
    logic [63:0]   rsp_data, mem_wdata;
    logic [63:0]   mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;

    amo_unit #(.ADDR_W(AW)) u_dut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    logic [7:0] mem_b [64];
    logic [7:0] exp_b [64];

    // Memory port signals captured away from the edge.
    logic l_rd, l_wr, l_lock;
    logic [AW-1:0] l_addr;
    logic [1:0] l_size;
    logic [63:0] l_wdata;

    always @(negedge clk) begin
        l_rd = mem_rd; l_wr = mem_wr; l_lock = mem_lock;
        l_addr = mem_addr; l_size = mem_size; l_wdata = mem_wdata;
        if (rst_n && (mem_rd || mem_wr)) begin
            total++;
            if (!mem_lock) begin
                bad++;
                $display("FAIL R12 access without lock: lock=%0b exp=1", mem_lock);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (l_rd) begin
            logic [63:0] r;
            r = '0;
            for (int i = 0; i < (1 << l_size); i++)
                r |= 64'(mem_b[(int'(l_addr) + i) & 63]) << (8 * i);
            mem_rdata <= r;
        end
        if (l_wr)
            for (int i = 0; i < (1 << l_size); i++)
                mem_b[(int'(l_addr) + i) & 63] = l_wdata[8*i +: 8];
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] get_el(input int a, input int sz);
        logic [63:0] r = '0;
        for (int i = 0; i < sz; i++) r |= 64'(exp_b[(a + i) & 63]) << (8 * i);
        return r;
    endfunction

    task automatic put_el(input int a, input int sz, input logic [63:0] v);
        for (int i = 0; i < sz; i++) exp_b[(a + i) & 63] = v[8*i +: 8];
    endtask

    task automatic preload(input int a, input int sz, input logic [63:0] v);
        for (int i = 0; i < sz; i++) begin
            exp_b[(a + i) & 63] = v[8*i +: 8];
            mem_b[(a + i) & 63] = v[8*i +: 8];
        end
    endtask

    function automatic logic signed [63:0] sx(input logic [63:0] v, input int sz);
        int sh = 64 - 8 * sz;
        return $signed(v << sh) >>> sh;
    endfunction

    task automatic compare_mem(input string tag);
        int diffs = 0;
        for (int i = 0; i < 64; i++) if (mem_b[i] !== exp_b[i]) diffs++;
        check(diffs == 0, tag, 64'(diffs), 64'd0);
    endtask

    // Issue one request, build the expectation, and judge the response.
    task automatic run_op(input logic st, input logic [4:0] fc, input int ew,
                          input int a, input logic [63:0] opa, input logic [63:0] opb,
                          input logic inject);
        int sz = 1 << ew;
        logic [63:0] m = (ew == 3) ? '1 : ((64'd1 << (8 * sz)) - 1);
        logic [63:0] v, nb, am, bm, nw, res, minneg;
        logic wr, legal, twin, cnt;
        int lat, exp_lat;
        v = get_el(a, sz); am = opa & m; bm = opb & m;
        minneg = 64'd1 << (8 * sz - 1);
        nb = (fc == 5'b11100) ? get_el(a - sz, sz) : get_el(a + sz, sz);
        legal = (fc[4:3] == 2'b00) || (fc == 5'b11000) ||
                (!st && (fc == 5'b01000 || fc == 5'b10000 || fc == 5'b11001 || fc == 5'b11100));
        twin = st && fc == 5'b11000;
        cnt = !st && (fc == 5'b11000 || fc == 5'b11001 || fc == 5'b11100);
        wr = legal; nw = v;
        case (fc)
            5'd0: nw = (v + am) & m;
            5'd1: nw = v ^ am;
            5'd2: nw = v | am;
            5'd3: nw = v & am;
            5'd4: nw = (am > v) ? am : v;
            5'd5: nw = (sx(am, sz) > sx(v, sz)) ? am : v;
            5'd6: nw = (am < v) ? am : v;
            5'd7: nw = (sx(am, sz) < sx(v, sz)) ? am : v;
            5'd8: nw = am;
            5'd16: begin wr = (v != am); nw = bm; end
            5'd24: if (twin) begin wr = (v == nb); nw = am; end
                   else begin wr = (v != nb); nw = (v + 1) & m; end
            5'd25: begin wr = (v == nb); nw = (v + 1) & m; end
            5'd28: begin wr = (v != nb); nw = (v - 1) & m; end
            default: wr = 1'b0;
        endcase
        wr = wr && legal;
        res = (cnt && !wr) ? minneg : v;
        if (wr) begin
            put_el(a, sz, nw);
            if (twin) put_el(a + sz, sz, nw);
        end
        exp_lat = !legal ? 1 : ((twin && wr) ? 5 : 4);

        @(negedge clk);
        req_valid = 1; req_store = st; req_fc = fc; req_ew = 2'(ew);
        req_addr = AW'(a); req_opa = opa; req_opb = opb;
        @(negedge clk);
        req_valid = inject;
        req_fc = 5'b01000; req_store = 0; req_addr = '0; req_opa = '1; req_ew = 2'd3;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            req_valid = 0;
            lat++;
        end
        req_valid = 0;
        check(lat == exp_lat, "R11 latency", 64'(lat), 64'(exp_lat));
        check(rsp_err == !legal, "R10 error flag", 64'(rsp_err), 64'(!legal));
        check(rsp_wb == (legal && !st), "R8 write-back strobe", 64'(rsp_wb),
              64'(legal && !st));
        if (legal && !st) begin
            if (fc[4:3] == 2'b00) check(rsp_data == res, "R2/R3 result", rsp_data, res);
            else if (fc == 5'b11100) check(rsp_data == res, "R7 result", rsp_data, res);
            else if (cnt) check(rsp_data == res, "R6 result", rsp_data, res);
            else check(rsp_data == res, "R5 R4 result", rsp_data, res);
        end
        compare_mem(st ? "R9 memory image" : "R1 memory image");
        @(negedge clk);
        check(!done && !busy, "R11 done one cycle", 64'(done), 64'd0);
    endtask

    logic [63:0] pv [4] = '{64'h8000_7FFF_80FF_7F80, 64'h0123_4567_89AB_CDEF,
                            64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF};
    logic [63:0] pa [4] = '{64'h7FFF_8000_7F01_8081, 64'hFEDC_BA98_7654_3210,
                            64'h0000_0000_0000_0001, 64'h0};
    logic [63:0] pn [4] = '{64'h1111_2222_3333_4444, 64'h0123_4567_89AB_CDEE,
                            64'h0, 64'h0000_0000_0000_0000};
    logic [63:0] pb [4] = '{64'hDEAD_BEEF_CAFE_F00D, 64'h5A5A_A5A5_5A5A_A5A5,
                            64'h0102_0304_0506_0708, 64'hF0F0_0F0F_F0F0_0F0F};
    logic [4:0] ld_fc [13] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
                               5'd8, 5'd16, 5'd24, 5'd25, 5'd28};
    logic [4:0] st_fc [9] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd24};

    task automatic sweep(input logic st, input logic [4:0] fc);
        for (int ew = 0; ew < 4; ew++) begin
            for (int k = 0; k < 4; k++) begin
                int sz = 1 << ew;
                logic [63:0] v = pv[k];
                logic [63:0] nb = (k == 2) ? pv[k] : pn[k];
                logic [63:0] a = (k == 3) ? pv[k] : pa[k];
                preload(32, sz, v);
                preload(32 + sz, sz, nb);
                preload(32 - sz, sz, nb);
                run_op(st, fc, ew, 32, a, pb[k], 1'b0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem_b[i] = 8'(i * 37 + 5);
            exp_b[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_lock && !mem_rd && !mem_wr && !rsp_wb && !rsp_err,
              "R11 reset state", {57'd0, busy, done, mem_lock, mem_rd, mem_wr, rsp_wb, rsp_err},
              64'd0);
        rst_n = 1;
        @(negedge clk);
        foreach (ld_fc[i]) sweep(1'b0, ld_fc[i]);
        foreach (st_fc[i]) sweep(1'b1, st_fc[i]);
        // R10: unsupported codes for both request types.
        run_op(1'b0, 5'b01001, 2, 32, 64'h55, 64'h66, 1'b0);
        run_op(1'b0, 5'b11111, 0, 32, 64'h55, 64'h66, 1'b0);
        run_op(1'b0, 5'b10001, 3, 32, 64'h55, 64'h66, 1'b0);
        run_op(1'b1, 5'b01000, 1, 32, 64'h55, 64'h66, 1'b0);
        run_op(1'b1, 5'b10000, 2, 32, 64'h55, 64'h66, 1'b0);
        run_op(1'b1, 5'b11100, 3, 32, 64'h55, 64'h66, 1'b0);
        // R11: a swap to address 0 presented while busy must leave memory alone.
        preload(0, 8, 64'h0011_2233_4455_6677);
        preload(40, 8, 64'h1234);
        run_op(1'b0, 5'd0, 3, 40, 64'h10, 64'h0, 1'b1);
        run_op(1'b1, 5'd24, 1, 40, 64'h10, 64'h0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d exp=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule